// File: doc/BRIEF.md
# SDRAM Presence-Detect Image Builder

This block turns a memory family code and a module capacity in megabytes into the 256-byte presence-detect image that a memory module reports to the host. A start pulse captures the inputs. The block then rounds the capacity down to a power of two and resolves the family against the per-bank size window of that family. It spreads the capacity over up to eight banks, one reduction step per clock. Last, it packs the per-bank density into a family-specific density byte.

Once the geometry is settled, the image is streamed with its index, one byte per clock, from index 0 to index 255. Every byte is generated from the index, so no image storage is kept. The checksum is accumulated while bytes 0 to 62 go out and is emitted at index 63. Four flags report the outcome of the last request: capacity too small, capacity not a power of two, family changed, and capacity truncated. A one-cycle done pulse closes each request.

Top module: `spd_gen`

## Requirements
- R1: A start pulse is accepted only while `busy_o` is low, and the block then raises `busy_o`. A start pulse while busy has no effect on the image or the flags.
- R2: A capacity below 4 MB sets `err_small_o`, streams no bytes, and ends with a `done_o` pulse.
- R3: The capacity is rounded down to the largest power of two not above it, called P. `warn_pow2_o` is set when rounding changed the value.
- R4: Family codes are SDR = 4, DDR = 7 and DDR2 = 8, and any other code is taken as SDR. The per-bank log2(MB) window is 2..9 for SDR, 5..12 for DDR and 7..14 for DDR2. When log2(P) is below the window minimum, the family becomes DDR if P >= 32, and SDR otherwise, and `warn_type_o` is set.
- R5: Starting at one bank with L = log2(P), each step lowers L by one and adds a bank, for as long as L exceeds the window maximum and the bank count is below 8. `warn_trunc_o` is set when banks * 2^L < P.
- R6: When a single bank remains and L is above the window minimum, L is lowered by one and the bank count becomes 2.
- R7: Byte 31 holds the density d = 2^(L-2), packed as follows. DDR2: (d & 0xE0) | ((d >> 8) & 0x1F). DDR: (d & 0xF8) | ((d >> 8) & 0x07). SDR: d & 0xFF.
- R8: Byte 2 holds the final family code. Byte 5 holds banks-1 for DDR2 and banks for the other families. Bytes 15 and 19 are 0 for DDR2 and 1 for the other families.
- R9: These bytes are fixed, given as index:value. 0:128, 1:8, 3:13, 4:10, 6:64, 8:4, 9:0x25, 10:1, 12:0x82, 13:8, 16:12, 17:4, 18:12, 20:2, 23:0x12, 27:20, 28:15, 29:20, 30:45, 32:20, 33:8, 34:20, 35:8. Every byte not named in R7 to R10 is 0.
- R10: Byte 63 is the sum modulo 256 of bytes 0 through 62.
- R11: For a valid request, `byte_valid_o` is high for exactly 256 consecutive cycles while `byte_idx_o` runs from 0 to 255. `done_o` pulses for one cycle in the cycle after index 255. The flags stay stable from `done_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse |
| mem_type_i | input | 4 | Requested family code (4, 7 or 8) |
| size_mb_i | input | SIZE_W | Module capacity in MB |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_small_o | output | 1 | Capacity below 4 MB |
| warn_pow2_o | output | 1 | Capacity was rounded down |
| warn_type_o | output | 1 | Family was changed |
| warn_trunc_o | output | 1 | Bank cap could not hold the capacity |
| byte_valid_o | output | 1 | Image byte present |
| byte_idx_o | output | 8 | Image byte index |
| byte_data_o | output | 8 | Image byte value |

## Verification
The bench builds the block with SIZE_W = 18 and MAX_BANKS = 8. A capacity of 2^17 MB is then in reach, which drives an SDR request through all seven reduction steps into the bank cap and the truncation flag. The same width also covers the small-capacity family fallbacks, both a downgrade to DDR and a downgrade to SDR. A reference model in the bench, written from the requirements, predicts each full image, and the captured stream is compared with it byte by byte.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [3:0] {
    MT_SDR  = 4'd4,
    MT_DDR  = 4'd7,
    MT_DDR2 = 4'd8
  } mem_type_e;

  function automatic mem_type_e decode_type(logic [3:0] code);
    case (code)
      4'd7:    return MT_DDR;
      4'd8:    return MT_DDR2;
      default: return MT_SDR;
    endcase
  endfunction

  function automatic logic [7:0] lg_min(mem_type_e t);
    case (t)
      MT_DDR:  return 8'd5;
      MT_DDR2: return 8'd7;
      default: return 8'd2;
    endcase
  endfunction

  function automatic logic [7:0] lg_max(mem_type_e t);
    case (t)
      MT_DDR:  return 8'd12;
      MT_DDR2: return 8'd14;
      default: return 8'd9;
    endcase
  endfunction

  function automatic logic [7:0] pack_density(mem_type_e t, logic [7:0] lg);
    logic [15:0] d;
    d = 16'(1) << (lg - 8'd2);
    case (t)
      MT_DDR2: return (d[7:0] & 8'hE0) | (d[15:8] & 8'h1F);
      MT_DDR:  return (d[7:0] & 8'hF8) | (d[15:8] & 8'h07);
      default: return d[7:0];
    endcase
  endfunction

  // constant fields of the image; 0 elsewhere
  function automatic logic [7:0] fixed_byte(logic [7:0] idx);
    case (idx)
      8'd0:    return 8'd128;
      8'd1:    return 8'd8;
      8'd3:    return 8'd13;
      8'd4:    return 8'd10;
      8'd6:    return 8'd64;
      8'd8:    return 8'd4;
      8'd9:    return 8'h25;
      8'd10:   return 8'd1;
      8'd12:   return 8'h82;
      8'd13:   return 8'd8;
      8'd16:   return 8'd12;
      8'd17:   return 8'd4;
      8'd18:   return 8'd12;
      8'd20:   return 8'd2;
      8'd23:   return 8'h12;
      8'd27:   return 8'd20;
      8'd28:   return 8'd15;
      8'd29:   return 8'd20;
      8'd30:   return 8'd45;
      8'd32:   return 8'd20;
      8'd33:   return 8'd8;
      8'd34:   return 8'd20;
      8'd35:   return 8'd8;
      default: return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/spd_geom.sv
module spd_geom
  import spd_pkg::*;
#(
  parameter int SIZE_W    = 20,
  parameter int MAX_BANKS = 8,
  localparam int LG_W     = $clog2(SIZE_W),
  localparam int BANK_W   = $clog2(MAX_BANKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        type_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              done_o,
  output logic              err_small_o,
  output logic              warn_pow2_o,
  output logic              warn_type_o,
  output logic              warn_trunc_o,
  output mem_type_e         type_o,
  output logic [BANK_W-1:0] banks_o,
  output logic [LG_W-1:0]   lg_o
);
  localparam int CAP_W = SIZE_W + BANK_W;

  typedef enum logic [1:0] {G_IDLE, G_REDUCE, G_SPLIT, G_OUT} gstate_e;

  gstate_e           state_q;
  mem_type_e         type_q;
  logic [LG_W-1:0]   lg_q, lg0_q;
  logic [BANK_W-1:0] banks_q;
  logic              small_q, pow2_q, tchg_q, trunc_q;

  logic [LG_W-1:0] lg_c;
  logic            small_c, pow2_c, below_c;
  mem_type_e       t_in_c, t_adj_c;
  logic [CAP_W-1:0] cap_c, p2_c;

  always_comb begin
    lg_c = '0;
    for (int i = 0; i < SIZE_W; i++)
      if (size_i[i]) lg_c = LG_W'(i);
  end

  assign small_c = size_i < SIZE_W'(4);
  assign pow2_c  = size_i != (SIZE_W'(1) << lg_c);
  assign t_in_c  = decode_type(type_i);
  assign below_c = 8'(lg_c) < lg_min(t_in_c);
  // P >= 32 <=> log2(P) >= 5
  assign t_adj_c = !below_c ? t_in_c : ((8'(lg_c) >= 8'd5) ? MT_DDR : MT_SDR);

  assign p2_c  = CAP_W'(1) << lg0_q;
  assign cap_c = CAP_W'(banks_q) << lg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= G_IDLE;
      type_q  <= MT_SDR;
      lg_q    <= '0;
      lg0_q   <= '0;
      banks_q <= BANK_W'(1);
      small_q <= 1'b0;
      pow2_q  <= 1'b0;
      tchg_q  <= 1'b0;
      trunc_q <= 1'b0;
    end else begin
      case (state_q)
        G_IDLE: if (start_i) begin
          type_q  <= t_adj_c;
          lg_q    <= lg_c;
          lg0_q   <= lg_c;
          banks_q <= BANK_W'(1);
          small_q <= small_c;
          pow2_q  <= !small_c && pow2_c;
          tchg_q  <= !small_c && below_c;
          trunc_q <= 1'b0;
          state_q <= small_c ? G_OUT : G_REDUCE;
        end
        G_REDUCE: begin
          if (8'(lg_q) > lg_max(type_q) && banks_q < BANK_W'(MAX_BANKS)) begin
            lg_q    <= lg_q - LG_W'(1);
            banks_q <= banks_q + BANK_W'(1);
          end else begin
            state_q <= G_SPLIT;
          end
        end
        G_SPLIT: begin
          trunc_q <= p2_c > cap_c;
          if (banks_q == BANK_W'(1) && 8'(lg_q) > lg_min(type_q)) begin
            lg_q    <= lg_q - LG_W'(1);
            banks_q <= BANK_W'(2);
          end
          state_q <= G_OUT;
        end
        default: state_q <= G_IDLE;
      endcase
    end
  end

  assign done_o       = state_q == G_OUT;
  assign err_small_o  = small_q;
  assign warn_pow2_o  = pow2_q;
  assign warn_type_o  = tchg_q;
  assign warn_trunc_o = trunc_q;
  assign type_o       = type_q;
  assign banks_o      = banks_q;
  assign lg_o         = lg_q;

  AST_BANK_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    banks_q <= BANK_W'(MAX_BANKS)); // R5

  AST_REDUCE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == G_REDUCE |=> (banks_q == $past(banks_q)) ||
                            (banks_q == $past(banks_q) + BANK_W'(1) && lg_q == $past(lg_q) - LG_W'(1))); // R5

endmodule

// File: rtl/spd_image.sv
module spd_image
  import spd_pkg::*;
#(
  parameter int LG_W   = 5,
  parameter int BANK_W = 4
) (
  input  logic [7:0]        idx_i,
  input  mem_type_e         type_i,
  input  logic [BANK_W-1:0] banks_i,
  input  logic [LG_W-1:0]   lg_i,
  output logic [7:0]        byte_o
);
  logic is_ddr2;
  assign is_ddr2 = type_i == MT_DDR2;

  always_comb begin
    case (idx_i)
      8'd2:    byte_o = 8'(type_i);
      8'd5:    byte_o = is_ddr2 ? 8'(banks_i) - 8'd1 : 8'(banks_i);
      8'd15,
      8'd19:   byte_o = is_ddr2 ? 8'd0 : 8'd1;
      8'd31:   byte_o = pack_density(type_i, 8'(lg_i));
      default: byte_o = fixed_byte(idx_i);
    endcase
  end

endmodule

// File: rtl/spd_gen.sv
module spd_gen
  import spd_pkg::*;
#(
  parameter int SIZE_W    = 20,
  parameter int MAX_BANKS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        mem_type_i,
  input  logic [SIZE_W-1:0] size_mb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_small_o,
  output logic              warn_pow2_o,
  output logic              warn_type_o,
  output logic              warn_trunc_o,
  output logic              byte_valid_o,
  output logic [7:0]        byte_idx_o,
  output logic [7:0]        byte_data_o
);
  localparam int LG_W   = $clog2(SIZE_W);
  localparam int BANK_W = $clog2(MAX_BANKS + 1);
  localparam logic [7:0] SUM_IDX  = 8'd63;
  localparam logic [7:0] LAST_IDX = 8'd255;

  typedef enum logic [1:0] {T_IDLE, T_GEOM, T_STREAM, T_DONE} tstate_e;

  tstate_e           state_q;
  logic [7:0]        idx_q, sum_q;
  logic              geo_done;
  mem_type_e         geo_type;
  logic [BANK_W-1:0] geo_banks;
  logic [LG_W-1:0]   geo_lg;
  logic [7:0]        img_byte;
  logic              accept;

  assign accept = start_i && state_q == T_IDLE;

  spd_geom #(.SIZE_W(SIZE_W), .MAX_BANKS(MAX_BANKS)) u_geom (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept),
    .type_i       (mem_type_i),
    .size_i       (size_mb_i),
    .done_o       (geo_done),
    .err_small_o  (err_small_o),
    .warn_pow2_o  (warn_pow2_o),
    .warn_type_o  (warn_type_o),
    .warn_trunc_o (warn_trunc_o),
    .type_o       (geo_type),
    .banks_o      (geo_banks),
    .lg_o         (geo_lg)
  );

  spd_image #(.LG_W(LG_W), .BANK_W(BANK_W)) u_image (
    .idx_i   (idx_q),
    .type_i  (geo_type),
    .banks_i (geo_banks),
    .lg_i    (geo_lg),
    .byte_o  (img_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= T_IDLE;
      idx_q   <= '0;
      sum_q   <= '0;
    end else begin
      case (state_q)
        T_IDLE: if (accept) state_q <= T_GEOM;
        T_GEOM: if (geo_done) begin
          idx_q   <= '0;
          sum_q   <= '0;
          state_q <= err_small_o ? T_DONE : T_STREAM;
        end
        T_STREAM: begin
          // checksum gathers bytes 0..62 as they leave
          if (idx_q < SUM_IDX) sum_q <= sum_q + img_byte;
          if (idx_q == LAST_IDX) state_q <= T_DONE;
          else idx_q <= idx_q + 8'd1;
        end
        default: state_q <= T_IDLE;
      endcase
    end
  end

  assign busy_o       = state_q != T_IDLE;
  assign done_o       = state_q == T_DONE;
  assign byte_valid_o = state_q == T_STREAM;
  assign byte_idx_o   = idx_q;
  assign byte_data_o  = (idx_q == SUM_IDX) ? sum_q : img_byte;

  AST_STREAM_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && $past(byte_valid_o) |-> byte_idx_o == $past(byte_idx_o) + 8'd1); // R11

  AST_STREAM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_valid_o) |-> byte_idx_o == 8'd0); // R11

  AST_ERR_NO_STREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_small_o |-> !byte_valid_o); // R2

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11

  AST_FLAGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && $past(start_i) |-> $stable(err_small_o)); // R1

endmodule

// File: tb/spd_gen_tb.sv
module spd_gen_tb;
  localparam int SIZE_W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mtype = 4'd4;
  logic [SIZE_W-1:0] size = '0;
  logic busy, done, e_small, w_pow2, w_type, w_trunc, bvalid;
  logic [7:0] bidx, bdata;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  int exp_img [256];
  int got_img [256];
  bit x_small, x_pow2, x_type, x_trunc;

  always #4 clk = ~clk;

  spd_gen #(.SIZE_W(SIZE_W), .MAX_BANKS(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mem_type_i(mtype),
    .size_mb_i(size), .busy_o(busy), .done_o(done), .err_small_o(e_small),
    .warn_pow2_o(w_pow2), .warn_type_o(w_type), .warn_trunc_o(w_trunc),
    .byte_valid_o(bvalid), .byte_idx_o(bidx), .byte_data_o(bdata)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(int tcode, int sz);
    int t, lg, p2, nb, mn, mx, d, pk, s;
    for (int i = 0; i < 256; i++) exp_img[i] = 0;
    x_small = 0; x_pow2 = 0; x_type = 0; x_trunc = 0;
    if (sz < 4) begin x_small = 1; return; end
    t = (tcode == 7) ? 7 : (tcode == 8) ? 8 : 4;
    lg = 0;
    for (int i = 0; i < 31; i++) if (sz >= (1 << i)) lg = i;
    p2 = 1 << lg;
    x_pow2 = sz != p2;
    mn = (t == 7) ? 5 : (t == 8) ? 7 : 2;
    if (lg < mn) begin
      x_type = 1;
      t = (p2 >= 32) ? 7 : 4;
    end
    mn = (t == 7) ? 5 : (t == 8) ? 7 : 2;
    mx = (t == 7) ? 12 : (t == 8) ? 14 : 9;
    nb = 1;
    while (lg > mx && nb < 8) begin lg--; nb++; end
    x_trunc = p2 > (1 << lg) * nb;
    if (nb == 1 && lg > mn) begin lg--; nb = 2; end
    d = 1 << (lg - 2);
    if (t == 8)      pk = (d & 'hE0) | ((d >> 8) & 'h1F);
    else if (t == 7) pk = (d & 'hF8) | ((d >> 8) & 'h07);
    else             pk = d & 'hFF;
    exp_img[0] = 128; exp_img[1] = 8; exp_img[2] = t; exp_img[3] = 13;
    exp_img[4] = 10; exp_img[5] = (t == 8) ? nb - 1 : nb; exp_img[6] = 64;
    exp_img[8] = 4; exp_img[9] = 'h25; exp_img[10] = 1; exp_img[12] = 'h82;
    exp_img[13] = 8; exp_img[15] = (t == 8) ? 0 : 1; exp_img[16] = 12;
    exp_img[17] = 4; exp_img[18] = 12; exp_img[19] = (t == 8) ? 0 : 1;
    exp_img[20] = 2; exp_img[23] = 'h12; exp_img[27] = 20; exp_img[28] = 15;
    exp_img[29] = 20; exp_img[30] = 45; exp_img[31] = pk; exp_img[32] = 20;
    exp_img[33] = 8; exp_img[34] = 20; exp_img[35] = 8;
    s = 0;
    for (int i = 0; i < 63; i++) s += exp_img[i];
    exp_img[63] = s & 255;
  endtask

  task automatic run_case(string name, int tcode, int sz, bit disturb);
    int nbytes, order_err, mism, cyc, sum;
    bit fin;
    $display("case %s: type %0d size %0d", name, tcode, sz);
    model(tcode, sz);
    for (int i = 0; i < 256; i++) got_img[i] = -1;
    @(negedge clk);
    mtype = 4'(tcode); size = SIZE_W'(sz); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 busy after start", int'(busy), 1);
    nbytes = 0; order_err = 0; cyc = 0; fin = 0;
    while (!fin && cyc < 2000) begin
      if (disturb && cyc == 3) begin mtype = 4'd8; size = SIZE_W'(2); start = 1'b1; end
      if (disturb && cyc == 4) start = 1'b0;
      if (bvalid) begin
        if (int'(bidx) != nbytes) order_err++;
        got_img[bidx] = int'(bdata);
        nbytes++;
      end
      if (done) fin = 1;
      else begin @(negedge clk); cyc++; end
    end
    check("R11 done seen", int'(fin), 1);
    check("R2 small flag", int'(e_small), int'(x_small));
    if (x_small) begin
      check("R2 no bytes streamed", nbytes, 0);
    end else begin
      check("R3 pow2 flag", int'(w_pow2), int'(x_pow2));
      check("R4 type flag", int'(w_type), int'(x_type));
      check("R5 trunc flag", int'(w_trunc), int'(x_trunc));
      check("R11 byte count", nbytes, 256);
      check("R11 index order errors", order_err, 0);
      check("R8 byte2 type", got_img[2], exp_img[2]);
      check("R8 byte5 banks", got_img[5], exp_img[5]);
      check("R6 byte5 banks", got_img[5], exp_img[5]);
      check("R8 byte15", got_img[15], exp_img[15]);
      check("R8 byte19", got_img[19], exp_img[19]);
      check("R7 byte31 density", got_img[31], exp_img[31]);
      sum = 0;
      for (int i = 0; i < 63; i++) sum += got_img[i];
      check("R10 byte63 checksum", got_img[63], sum & 255);
      mism = 0;
      for (int i = 0; i < 256; i++)
        if (got_img[i] != exp_img[i]) begin
          if (mism == 0) check("R9 image byte", got_img[i], exp_img[i]);
          mism++;
        end
      check("R9 image mismatches", mism, 0);
    end
    @(negedge clk);
    check("R11 done one cycle", int'(done), 0);
    check("R11 flags held", int'(e_small), int'(x_small));
    check("R1 idle after done", int'(busy), 0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset busy", int'(busy), 0);
    check("R11 reset valid", int'(bvalid), 0);
    check("R11 reset done", int'(done), 0);
    check("R2 reset flag", int'(e_small), 0);
    rst_n = 1'b1;
    run_case("R2 too small",            4, 2,      0);
    run_case("R6 sdr split",            4, 64,     0);
    run_case("R3 ddr round down",       7, 100,    0);
    run_case("R4 ddr2 to sdr",          8, 16,     0);
    run_case("R4 ddr2 to ddr",          8, 32,     0);
    run_case("R7 ddr2 density",         8, 8192,   0);
    run_case("R7 ddr density",          7, 4096,   0);
    run_case("R5 sdr bank cap",         4, 131072, 0);
    run_case("R4 unknown code as sdr",  3, 256,    0);
    run_case("R1 start ignored busy",   7, 100,    1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule